// File: doc/BRIEF.md
# Segmented Register File with Physical Address Generation

This block holds the architectural register state of a 16-bit processor core and forms its 20-bit physical addresses. Fourteen 16-bit registers are kept in one array. The first four are general data registers: they can be read and written as a whole word, or through either 8-bit half on its own. Two registers, a code segment register and an instruction pointer, set the instruction fetch address.

Two combinational read ports and one synchronous write port each carry a register index and an access-size select. The fetch sequencer moves the fetch position with an advance input, which adds an instruction length to the pointer, and a jump input, which loads segment and pointer together. A free-standing translator turns any segment/offset pair into a physical address, so the data path can address memory without going through the register array.

Physical addresses are always the segment shifted left by four bits plus the offset, truncated to 20 bits. Many segment/offset pairs name the same location, and the block treats that as normal.

Top module: `seg_regfile`

## Requirements
- R1: Register indices 0 to 13 select the fourteen registers. A read of index 14 or 15 returns zero, and a write to either index changes no register.
- R2: A word write to any register is visible on both read ports after the next rising clock edge. A read of a register in the same cycle it is written returns the value it held before that edge.
- R3: For indices 0 to 3 the access select is decoded as 00 word, 01 low byte (bits 7:0), 10 high byte (bits 15:8) and 11 word. A byte read returns the selected half in bits 7:0 with bits 15:8 zero. A byte write takes its value from write data bits 7:0 and leaves the other half unchanged.
- R4: For indices 4 to 13 the access select is ignored and every access is a full word.
- R5: The translator output equals translator segment × 16 + translator offset, modulo 2^20, in the same cycle, for every pair, including pairs that alias the same address.
- R6: The fetch address equals code segment (index 9) × 16 + instruction pointer (index 12), modulo 2^20. A write-port update of either register moves it after the next edge.
- R7: An advance adds the 3-bit advance length (1 to 6 in use) to the instruction pointer, modulo 2^16, at the next edge, and leaves the code segment unchanged.
- R8: A jump loads the code segment and instruction pointer together at one edge. A jump overrides an advance and write-port updates of those two registers in the same cycle. An advance overrides a write-port update of the instruction pointer.
- R9: A synchronous reset loads the code segment with FFFFh and clears every other register, so the fetch address after reset is FFFF0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_sel | input | 2 | Read port A access select |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_sel | input | 2 | Read port B access select |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register index |
| wr_sel | input | 2 | Write port access select |
| wr_data | input | 16 | Write port data |
| adv_en | input | 1 | Advance the instruction pointer |
| adv_len | input | 3 | Advance length in bytes |
| jmp_en | input | 1 | Load code segment and instruction pointer |
| jmp_seg | input | 16 | Jump segment value |
| jmp_off | input | 16 | Jump pointer value |
| fetch_addr | output | 20 | Instruction fetch physical address |
| xl_seg | input | 16 | Translator segment input |
| xl_off | input | 16 | Translator offset input |
| xl_addr | output | 20 | Translator physical address |

## Verification
Read data, the fetch address and the translator result are all combinational, so a translator result or a read of unchanged state is due in the cycle its inputs are applied. Any write, advance, jump or reset shows up in exactly one cycle, at the sample after the next rising edge. The driver tags each expected item with the cycle number at which it is due. The monitor samples shortly before the following edge and compares only items due in that cycle. As a result, the old-value read in a write cycle and the new value one cycle later are checked at two distinct sample points.

// File: rtl/seg_rf_pkg.sv
package seg_rf_pkg;
   typedef enum logic [1:0] {
      ACC_WORD  = 2'b00,
      ACC_LO    = 2'b01,
      ACC_HI    = 2'b10,
      ACC_WORD2 = 2'b11
   } acc_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);
   localparam int BASE_W = SEG_W + SHIFT;

   if (ADDR_W < OFF_W || ADDR_W > BASE_W + 1) begin : g_bad_width
      $error("seg_addr_gen: ADDR_W out of range");
   end

   logic [BASE_W-1:0] base;
   assign base = {seg, {SHIFT{1'b0}}};
   // carry past the top address bit is dropped: the space wraps
   assign addr = ADDR_W'(base) + ADDR_W'(off);
endmodule

// File: rtl/seg_read_port.sv
module seg_read_port
   import seg_rf_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 14,
   parameter int NUM_GP   = 4,
   parameter int IDX_W    = 4
) (
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   input  logic [IDX_W-1:0]           idx,
   input  logic [1:0]                 sel,
   output logic [DATA_W-1:0]          data
);
   localparam int HALF = DATA_W / 2;
   localparam logic [IDX_W-1:0] GP_LIM = IDX_W'(NUM_GP);

   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == IDX_W'(i)) word = regs_flat[i*DATA_W +: DATA_W];
      end
      data = word;
      if (idx < GP_LIM) begin
         if (sel == ACC_LO)      data = {{HALF{1'b0}}, word[HALF-1:0]};
         else if (sel == ACC_HI) data = {{HALF{1'b0}}, word[DATA_W-1:HALF]};
      end
   end
endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl #(
   parameter int DATA_W = 16,
   parameter int ADV_W  = 3
) (
   input  logic              jmp_en,
   input  logic [DATA_W-1:0] jmp_seg,
   input  logic [DATA_W-1:0] jmp_off,
   input  logic              adv_en,
   input  logic [ADV_W-1:0]  adv_len,
   input  logic [DATA_W-1:0] ip_q,
   output logic              cs_ld,
   output logic [DATA_W-1:0] cs_val,
   output logic              ip_ld,
   output logic [DATA_W-1:0] ip_val
);
   if (ADV_W >= DATA_W) begin : g_bad_adv
      $error("seg_fetch_ctrl: ADV_W must be narrower than DATA_W");
   end

   assign cs_ld  = jmp_en;
   assign cs_val = jmp_seg;
   assign ip_ld  = jmp_en | adv_en;
   assign ip_val = jmp_en ? jmp_off : ip_q + DATA_W'(adv_len);
endmodule

// File: rtl/seg_reg_array.sv
module seg_reg_array
   import seg_rf_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter int              NUM_REGS = 14,
   parameter int              NUM_GP   = 4,
   parameter int              IDX_W    = 4,
   parameter int              CS_IDX   = 9,
   parameter int              IP_IDX   = 12,
   parameter logic [DATA_W-1:0] CS_RST = 16'hFFFF
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [1:0]                 wr_sel,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       cs_ld,
   input  logic [DATA_W-1:0]          cs_val,
   input  logic                       ip_ld,
   input  logic [DATA_W-1:0]          ip_val,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   localparam int HALF = DATA_W / 2;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [DATA_W-1:0] RST_V = (g == CS_IDX) ? CS_RST : '0;
      logic [DATA_W-1:0] q, d;
      logic              hit, ovr;
      logic [DATA_W-1:0] ovr_v;

      assign hit = wr_en && (wr_idx == IDX_W'(g));

      if (g < NUM_GP) begin : g_byte_lane
         always_comb begin
            case (wr_sel)
               ACC_LO:  d = {q[DATA_W-1:HALF], wr_data[HALF-1:0]};
               ACC_HI:  d = {wr_data[HALF-1:0], q[HALF-1:0]};
               default: d = wr_data;
            endcase
         end
      end else begin : g_word_lane
         assign d = wr_data;
      end

      if (g == CS_IDX) begin : g_cs
         assign ovr   = cs_ld;
         assign ovr_v = cs_val;
      end else if (g == IP_IDX) begin : g_ip
         assign ovr   = ip_ld;
         assign ovr_v = ip_val;
      end else begin : g_plain
         assign ovr   = 1'b0;
         assign ovr_v = '0;
      end

      always_ff @(posedge clk) begin
         if (rst)      q <= RST_V;
         else if (ovr) q <= ovr_v;
         else if (hit) q <= d;
      end

      assign regs_flat[g*DATA_W +: DATA_W] = q;
   end
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int              DATA_W   = 16,
   parameter int              NUM_REGS = 14,
   parameter int              NUM_GP   = 4,
   parameter int              SHIFT    = 4,
   parameter int              ADDR_W   = 20,
   parameter int              ADV_W    = 3,
   parameter int              CS_IDX   = 9,
   parameter int              IP_IDX   = 12,
   parameter logic [DATA_W-1:0] CS_RST = 16'hFFFF,
   localparam int             IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [1:0]        rd_a_sel,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   input  logic [1:0]        rd_b_sel,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              adv_en,
   input  logic [ADV_W-1:0]  adv_len,
   input  logic              jmp_en,
   input  logic [DATA_W-1:0] jmp_seg,
   input  logic [DATA_W-1:0] jmp_off,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic [DATA_W-1:0] xl_seg,
   input  logic [DATA_W-1:0] xl_off,
   output logic [ADDR_W-1:0] xl_addr
);
   localparam int NUM_RD = 2;

   if (DATA_W % 2 != 0) begin : g_bad_data
      $error("seg_regfile: DATA_W must be even");
   end
   if (NUM_GP > NUM_REGS || CS_IDX >= NUM_REGS || IP_IDX >= NUM_REGS) begin : g_bad_idx
      $error("seg_regfile: register index parameter out of range");
   end
   if (CS_IDX == IP_IDX || CS_IDX < NUM_GP || IP_IDX < NUM_GP) begin : g_bad_map
      $error("seg_regfile: fetch registers must be distinct word-only registers");
   end

   logic [NUM_REGS*DATA_W-1:0] regs_flat;
   logic [DATA_W-1:0]          cs_q, ip_q;
   logic                       cs_ld, ip_ld;
   logic [DATA_W-1:0]          cs_val, ip_val;

   logic [IDX_W-1:0]  rd_idx  [NUM_RD];
   logic [1:0]        rd_sel  [NUM_RD];
   logic [DATA_W-1:0] rd_data [NUM_RD];

   assign rd_idx[0] = rd_a_idx;
   assign rd_sel[0] = rd_a_sel;
   assign rd_idx[1] = rd_b_idx;
   assign rd_sel[1] = rd_b_sel;
   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];

   assign cs_q = regs_flat[CS_IDX*DATA_W +: DATA_W];
   assign ip_q = regs_flat[IP_IDX*DATA_W +: DATA_W];

   seg_fetch_ctrl #(.DATA_W(DATA_W), .ADV_W(ADV_W)) u_fetch (
      .jmp_en(jmp_en), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
      .adv_en(adv_en), .adv_len(adv_len), .ip_q(ip_q),
      .cs_ld(cs_ld), .cs_val(cs_val), .ip_ld(ip_ld), .ip_val(ip_val)
   );

   seg_reg_array #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_GP(NUM_GP), .IDX_W(IDX_W),
      .CS_IDX(CS_IDX), .IP_IDX(IP_IDX), .CS_RST(CS_RST)
   ) u_regs (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
      .cs_ld(cs_ld), .cs_val(cs_val), .ip_ld(ip_ld), .ip_val(ip_val),
      .regs_flat(regs_flat)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      seg_read_port #(
         .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_GP(NUM_GP), .IDX_W(IDX_W)
      ) u_port (
         .regs_flat(regs_flat), .idx(rd_idx[p]), .sel(rd_sel[p]), .data(rd_data[p])
      );
   end

   seg_addr_gen #(.SEG_W(DATA_W), .OFF_W(DATA_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_fetch_addr (
      .seg(cs_q), .off(ip_q), .addr(fetch_addr)
   );

   seg_addr_gen #(.SEG_W(DATA_W), .OFF_W(DATA_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_xlate (
      .seg(xl_seg), .off(xl_off), .addr(xl_addr)
   );
endmodule

// File: rtl/seg_regfile_chk.sv
module seg_regfile_chk #(
   parameter int              DATA_W   = 16,
   parameter int              NUM_REGS = 14,
   parameter int              NUM_GP   = 4,
   parameter int              SHIFT    = 4,
   parameter int              ADDR_W   = 20,
   parameter int              CS_IDX   = 9,
   parameter int              IP_IDX   = 12,
   parameter logic [DATA_W-1:0] CS_RST = 16'hFFFF,
   parameter int              IDX_W    = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [IDX_W-1:0]  rd_a_idx,
   input logic [1:0]        rd_a_sel,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [IDX_W-1:0]  rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [1:0]        wr_sel,
   input logic              adv_en,
   input logic              jmp_en,
   input logic [DATA_W-1:0] jmp_seg,
   input logic [DATA_W-1:0] jmp_off,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic [DATA_W-1:0] xl_seg,
   input logic [DATA_W-1:0] xl_off,
   input logic [ADDR_W-1:0] xl_addr
);
   localparam logic [IDX_W-1:0]  REG_LIM = IDX_W'(NUM_REGS);
   localparam logic [IDX_W-1:0]  GP_LIM  = IDX_W'(NUM_GP);
   localparam logic [IDX_W-1:0]  CS_I    = IDX_W'(CS_IDX);
   localparam logic [IDX_W-1:0]  IP_I    = IDX_W'(IP_IDX);
   localparam logic [ADDR_W-1:0] RST_FETCH = ADDR_W'({CS_RST, {SHIFT{1'b0}}});

   // R9: reset leaves the fetch position at the top segment, pointer zero
   assert_reset_fetch_R9: assert property (@(posedge clk)
      rst |=> (fetch_addr == RST_FETCH));

   // R1: out-of-range indices read as zero on both ports
   assert_oob_read_a_R1: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx >= REG_LIM) |-> (rd_a_data == '0));
   assert_oob_read_b_R1: assert property (@(posedge clk) disable iff (rst)
      (rd_b_idx >= REG_LIM) |-> (rd_b_data == '0));

   // R3: a low-byte write leaves the high half as read through port A
   assert_byte_keep_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx < GP_LIM && wr_sel == 2'b01 && rd_a_idx == wr_idx && rd_a_sel == 2'b10)
      ##1 (rd_a_idx == $past(rd_a_idx) && rd_a_sel == 2'b10)
      |-> $stable(rd_a_data));

   // R5 and R6: translator and fetch path agree when fed the live registers
   assert_xlate_matches_fetch_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx == CS_I && rd_b_idx == IP_I && xl_seg == rd_a_data && xl_off == rd_b_data)
      |-> (xl_addr == fetch_addr));

   // R8: a jump lands exactly on its target one edge later
   assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
      jmp_en |=> (fetch_addr ==
         ADDR_W'({$past(jmp_seg), {SHIFT{1'b0}}}) + ADDR_W'($past(jmp_off))));

   // R6: with no jump, advance or fetch-register write, the fetch address holds
   assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!jmp_en && !adv_en && !(wr_en && (wr_idx == CS_I || wr_idx == IP_I)))
      |=> $stable(fetch_addr));
endmodule

bind seg_regfile seg_regfile_chk #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_GP(NUM_GP), .SHIFT(SHIFT),
   .ADDR_W(ADDR_W), .CS_IDX(CS_IDX), .IP_IDX(IP_IDX), .CS_RST(CS_RST), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/tb_seg_regfile.sv
module tb_seg_regfile;
   localparam int P_A = 0, P_B = 1, P_F = 2, P_X = 3;

   typedef struct {
      int          due;
      int          port;
      logic [19:0] exp;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [1:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
   logic [15:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0, adv_en = 1'b0, jmp_en = 1'b0;
   logic [2:0]  adv_len = '0;
   logic [15:0] jmp_seg = '0, jmp_off = '0, xl_seg = '0, xl_off = '0;
   logic [19:0] fetch_addr, xl_addr;

   item_t q[$];
   int    cyc = 0;
   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   seg_regfile dut (
      .clk(clk), .rst(rst),
      .rd_a_idx(rd_a_idx), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
      .adv_en(adv_en), .adv_len(adv_len),
      .jmp_en(jmp_en), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
      .fetch_addr(fetch_addr),
      .xl_seg(xl_seg), .xl_off(xl_off), .xl_addr(xl_addr)
   );

   // expectation due in the current cycle
   task automatic expect_now(input int port, input logic [19:0] exp, input string req);
      item_t it;
      it.due = cyc; it.port = port; it.exp = exp; it.req = req;
      q.push_back(it);
   endtask

   task automatic nxt();
      @(negedge clk);
      wr_en = 1'b0; adv_en = 1'b0; jmp_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] idx, input logic [1:0] sel, input logic [15:0] d);
      wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_data = d;
   endtask

   // monitor: samples 1 ns before each rising edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [19:0] act;
            it = q.pop_front();
            case (it.port)
               P_A:     act = {4'h0, rd_a_data};
               P_B:     act = {4'h0, rd_b_data};
               P_F:     act = fetch_addr;
               default: act = xl_addr;
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s port%0d actual %05h expected %05h (cycle %0d)",
                        it.req, it.port, act, it.exp, cyc);
            end
         end
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      rst = 1'b0;
      expect_now(P_F, 20'hFFFF0, "R9");
      rd_a_idx = 4'd9;  rd_a_sel = 2'b00; expect_now(P_A, 20'h0FFFF, "R9");
      rd_b_idx = 4'd0;  rd_b_sel = 2'b00; expect_now(P_B, 20'h00000, "R9");
      // R2: same-cycle read is old value, new value next cycle
      nxt(); wr(4'd5, 2'b00, 16'h1234);
      rd_a_idx = 4'd5; expect_now(P_A, 20'h00000, "R2");
      nxt(); expect_now(P_A, 20'h01234, "R2");
      wr(4'd13, 2'b00, 16'hCAFE);
      nxt(); rd_b_idx = 4'd13; expect_now(P_B, 20'h0CAFE, "R2");
      wr(4'd0, 2'b00, 16'hA1B2);
      // R3: byte lanes of a general register
      nxt(); wr(4'd0, 2'b01, 16'h347C);
      rd_a_idx = 4'd0; rd_a_sel = 2'b00; expect_now(P_A, 20'h0A1B2, "R3");
      nxt(); expect_now(P_A, 20'h0A17C, "R3");
      rd_b_idx = 4'd0; rd_b_sel = 2'b10; expect_now(P_B, 20'h000A1, "R3");
      wr(4'd0, 2'b10, 16'h0055);
      nxt(); expect_now(P_A, 20'h0557C, "R3");
      rd_b_sel = 2'b01; expect_now(P_B, 20'h0007C, "R3");
      // R4: select ignored above the general registers
      nxt(); wr(4'd6, 2'b01, 16'hBEEF);
      nxt(); rd_a_idx = 4'd6; rd_a_sel = 2'b10; expect_now(P_A, 20'h0BEEF, "R4");
      // R1: index 14 neither stores nor disturbs
      wr(4'd14, 2'b00, 16'h7777);
      nxt(); rd_a_idx = 4'd14; rd_a_sel = 2'b00; expect_now(P_A, 20'h00000, "R1");
      rd_b_idx = 4'd13; rd_b_sel = 2'b00; expect_now(P_B, 20'h0CAFE, "R1");
      // R5: translator ranges, aliasing, wrap
      nxt(); xl_seg = 16'h1000; xl_off = 16'h0000; expect_now(P_X, 20'h10000, "R5");
      nxt(); xl_off = 16'hFFFF; expect_now(P_X, 20'h1FFFF, "R5");
      nxt(); xl_seg = 16'h1234; xl_off = 16'h0005; expect_now(P_X, 20'h12345, "R5");
      nxt(); xl_seg = 16'h1000; xl_off = 16'h2345; expect_now(P_X, 20'h12345, "R5");
      nxt(); xl_seg = 16'hFFFF; xl_off = 16'hFFFF; expect_now(P_X, 20'h0FFEF, "R5");
      // R6/R7: advances from the reset fetch position
      nxt(); adv_en = 1'b1; adv_len = 3'd3; expect_now(P_F, 20'hFFFF0, "R6");
      nxt(); adv_en = 1'b1; adv_len = 3'd6; expect_now(P_F, 20'hFFFF3, "R7");
      nxt(); expect_now(P_F, 20'hFFFF9, "R7");
      rd_a_idx = 4'd9; expect_now(P_A, 20'h0FFFF, "R7");
      jmp_en = 1'b1; jmp_seg = 16'h0000; jmp_off = 16'hFFFE;
      nxt(); adv_en = 1'b1; adv_len = 3'd5; expect_now(P_F, 20'h0FFFE, "R8");
      nxt(); expect_now(P_F, 20'h00003, "R7");
      // R8: priority among jump, advance and write port
      jmp_en = 1'b1; jmp_seg = 16'h2000; jmp_off = 16'h0010;
      adv_en = 1'b1; adv_len = 3'd4;
      nxt(); expect_now(P_F, 20'h20010, "R8");
      jmp_en = 1'b1; jmp_seg = 16'h3000; jmp_off = 16'h0000;
      wr(4'd12, 2'b00, 16'h9999);
      nxt(); expect_now(P_F, 20'h30000, "R8");
      adv_en = 1'b1; adv_len = 3'd2; wr(4'd12, 2'b00, 16'h1111);
      nxt(); expect_now(P_F, 20'h30002, "R8");
      // R6: write port moves the code segment
      wr(4'd9, 2'b00, 16'h4000);
      nxt(); expect_now(P_F, 20'h40002, "R6");
      rd_b_idx = 4'd12; expect_now(P_B, 20'h00002, "R6");
      // R9: reset in mid-run
      nxt(); rst = 1'b1;
      nxt(); rst = 1'b0;
      expect_now(P_F, 20'hFFFF0, "R9");
      rd_a_idx = 4'd5; rd_a_sel = 2'b00; expect_now(P_A, 20'h00000, "R9");
      rd_b_idx = 4'd0; rd_b_sel = 2'b00; expect_now(P_B, 20'h00000, "R9");
      nxt(); nxt(); nxt();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule